// File: doc/BRIEF.md
# Auto-Crossover Pair Resolution Controller

This controller chooses the wire-pair assignment of one Ethernet port: straight-through (MDI) or crossed (MDI-X). In automatic mode it hunts. It holds one assignment for a programmable slot, and if no link is seen when the slot ends, it swaps to the other assignment and starts a new slot. When a link is present at the end of a slot, it locks that assignment and raises a completion flag. In manual mode a control bit sets the assignment directly. Slot time is counted in ticks of an external 1 ms timebase strobe.

The block has three states. `ST_MANUAL` is entered at reset or on any write that leaves automatic mode off. `ST_HUNT` is entered on any write that leaves automatic mode on, and from `ST_LOCKED` when the link drops. `ST_LOCKED` is entered from `ST_HUNT` when a slot expires with the link present. A register write takes priority over every other transition.

The register is 16 bits wide. Bit 0 is the auto enable and bit 1 is the manual select; both are read/write. Bit 2 is the pair status and bit 3 is the completion flag; both are read-only. Bits 7:4 hold the slot code and are read/write. Bits 15:8 read 0.

Top module: `xover_ctrl`

## Requirements
- R1: After a synchronous reset, `rd_data` reads 0 and `pair_x` is 0 (MDI). Auto mode is off, the completion flag is clear and the slot code is 0.
- R2: A write stores `wr_data` bit 0 (auto enable), bit 1 (manual select) and bits 7:4 (slot code). Writes to bits 2 and 3 and to bits 15:8 have no effect, and bits 15:8 always read 0.
- R3: While auto enable is 0, `pair_x` takes the manual select value on the clock after the register holds it, and the completion flag (bit 3) reads 0.
- R4: While auto enable is 1, the manual select bit has no effect on `pair_x`.
- R5: The slot length is L = 80 + floor((25*code + 7) / 15) ticks: code 0 gives 80 and code 15 gives 105. While hunting, `pair_x` toggles on the L-th tick after the last restart or toggle if `link_ok` is 0 during that tick.
- R6: If `link_ok` is 1 during the L-th tick, `pair_x` is held, the completion flag reads 1 from that clock on, and no further toggles occur while the link stays up.
- R7: When `link_ok` falls while locked, the completion flag clears on the next clock. Hunting then resumes from the current assignment with a fresh slot.
- R8: Any register write that leaves auto enable at 1 clears the completion flag, restarts the slot count and keeps the current assignment.
- R9: Register bit 2 always equals `pair_x`: 1 means MDI-X and 0 means MDI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_ms | input | 1 | One-cycle timebase strobe, one per millisecond |
| link_ok | input | 1 | Link detected by the receive side |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register read value |
| pair_x | output | 1 | Selected pair assignment, 1 = crossed |

## Verification
The assertions assume that `tick_ms` is a single-cycle strobe and that `link_ok` is a level that is already synchronised to `clk`. They also assume that register writes are isolated single-cycle strobes. The bench drives the tick for exactly one clock, followed by idle clocks. It changes `link_ok` and the write strobe only at falling edges and never in the same cycle as a tick. As a result, the expiry, lock and restart events it checks fall on distinct, predictable clock edges.

// File: rtl/xover_pkg.sv
package xover_pkg;
    typedef enum logic [1:0] {
        ST_MANUAL = 2'd0,
        ST_HUNT   = 2'd1,
        ST_LOCKED = 2'd2
    } xo_state_e;

    localparam int unsigned FLD_AUTO     = 0;
    localparam int unsigned FLD_MANUAL   = 1;
    localparam int unsigned FLD_PAIR     = 2;
    localparam int unsigned FLD_DONE     = 3;
    localparam int unsigned FLD_CODE_LSB = 4;
endpackage

// File: rtl/xover_slot_timer.sv
module xover_slot_timer #(
    parameter int unsigned CODE_W = 4,
    parameter int unsigned BASE   = 80,
    parameter int unsigned SPAN   = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              expire
);
    localparam int unsigned STEPS   = (1 << CODE_W) - 1;
    localparam int unsigned MAX_LEN = BASE + SPAN;
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_q;
    int unsigned      len_calc;

    // Slot length: linear interpolation from BASE to BASE+SPAN, rounded half up.
    always_comb begin
        len_calc = BASE + (SPAN * int'(code) + STEPS / 2) / STEPS;
        last_q   = CNT_W'(len_calc - 1);
    end

    assign expire = tick && (cnt_q == last_q);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == last_q) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/xover_cfg_regs.sv
module xover_cfg_regs
    import xover_pkg::*;
#(
    parameter int unsigned REG_W  = 16,
    parameter int unsigned CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              pair_x,
    input  logic              done,
    output logic              auto_q,
    output logic              auto_nxt,
    output logic              manual_q,
    output logic [CODE_W-1:0] code_q,
    output logic [REG_W-1:0]  rd_data
);
    localparam int unsigned CODE_MSB = FLD_CODE_LSB + CODE_W - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_q   <= 1'b0;
            manual_q <= 1'b0;
            code_q   <= '0;
        end else if (wr_en) begin
            auto_q   <= wr_data[FLD_AUTO];
            manual_q <= wr_data[FLD_MANUAL];
            code_q   <= wr_data[CODE_MSB:FLD_CODE_LSB];
        end
    end

    // Mode that takes effect at this edge, seen by the state machine.
    assign auto_nxt = wr_en ? wr_data[FLD_AUTO] : auto_q;

    always_comb begin
        rd_data                         = '0;
        rd_data[FLD_AUTO]               = auto_q;
        rd_data[FLD_MANUAL]             = manual_q;
        rd_data[FLD_PAIR]               = pair_x;
        rd_data[FLD_DONE]               = done;
        rd_data[CODE_MSB:FLD_CODE_LSB]  = code_q;
    end
endmodule

// File: rtl/xover_fsm.sv
module xover_fsm
    import xover_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  logic      auto_nxt,
    input  logic      manual_q,
    input  logic      link_ok,
    input  logic      expire,
    output xo_state_e st_q,
    output logic      pair_x,
    output logic      done,
    output logic      tmr_clr
);
    xo_state_e st_d;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d = auto_nxt ? ST_HUNT : ST_MANUAL;
        end else begin
            unique case (st_q)
                ST_MANUAL: st_d = ST_MANUAL;
                ST_HUNT:   if (expire && link_ok) st_d = ST_LOCKED;
                ST_LOCKED: if (!link_ok) st_d = ST_HUNT;
                default:   st_d = ST_MANUAL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_MANUAL;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_x <= 1'b0;
        end else begin
            unique case (st_q)
                ST_MANUAL: pair_x <= manual_q;
                ST_HUNT:   if (!restart && expire && !link_ok) pair_x <= ~pair_x;
                ST_LOCKED: pair_x <= pair_x;
                default:   pair_x <= 1'b0;
            endcase
        end
    end

    assign done    = (st_q == ST_LOCKED);
    assign tmr_clr = restart || (st_q != ST_HUNT);
endmodule

// File: rtl/xover_ctrl.sv
module xover_ctrl
    import xover_pkg::*;
#(
    parameter int unsigned REG_W      = 16,
    parameter int unsigned CODE_W     = 4,
    parameter int unsigned BASE_TICKS = 80,
    parameter int unsigned SPAN_TICKS = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_ms,
    input  logic             link_ok,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             pair_x
);
    logic              auto_q;
    logic              auto_nxt;
    logic              manual_q;
    logic [CODE_W-1:0] code_q;
    logic              done;
    logic              tmr_clr;
    logic              expire;
    xo_state_e         st_q;

    xover_cfg_regs #(.REG_W(REG_W), .CODE_W(CODE_W)) i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .pair_x   (pair_x),
        .done     (done),
        .auto_q   (auto_q),
        .auto_nxt (auto_nxt),
        .manual_q (manual_q),
        .code_q   (code_q),
        .rd_data  (rd_data)
    );

    xover_slot_timer #(.CODE_W(CODE_W), .BASE(BASE_TICKS), .SPAN(SPAN_TICKS)) i_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (tmr_clr),
        .tick   (tick_ms),
        .code   (code_q),
        .expire (expire)
    );

    xover_fsm i_fsm (
        .clk      (clk),
        .rst      (rst),
        .restart  (wr_en),
        .auto_nxt (auto_nxt),
        .manual_q (manual_q),
        .link_ok  (link_ok),
        .expire   (expire),
        .st_q     (st_q),
        .pair_x   (pair_x),
        .done     (done),
        .tmr_clr  (tmr_clr)
    );
endmodule

// File: rtl/xover_ctrl_chk.sv
module xover_ctrl_chk
    import xover_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      link_ok,
    input logic      wr_en,
    input logic      pair_x,
    input logic      done,
    input logic      auto_q,
    input logic      manual_q,
    input logic      expire,
    input xo_state_e st_q
);
    AST_DONE_NEEDS_AUTO: assert property (@(posedge clk) disable iff (rst)
        done |-> auto_q); // R3

    AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(st_q == ST_MANUAL)) |-> (pair_x == $past(manual_q))); // R3

    AST_TOGGLE_ONLY_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(st_q == ST_HUNT) && (pair_x != $past(pair_x)))
            |-> $past(expire && !link_ok && !wr_en)); // R5

    AST_LOCK_HOLDS_PAIR: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(st_q == ST_LOCKED)) |-> $stable(pair_x)); // R6

    AST_DONE_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $rose(done)) |-> $past(expire && link_ok)); // R6

    AST_LINK_LOSS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(done && !link_ok)) |-> !done); // R7

    AST_WRITE_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(wr_en)) |-> !done); // R8
endmodule

bind xover_ctrl xover_ctrl_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .link_ok  (link_ok),
    .wr_en    (wr_en),
    .pair_x   (pair_x),
    .done     (done),
    .auto_q   (auto_q),
    .manual_q (manual_q),
    .expire   (expire),
    .st_q     (st_q)
);

// File: tb/test_xover_ctrl.sv
module test_xover_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_ms = 1'b0;
    logic        link_ok = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        pair_x;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    xover_ctrl i_xover_ctrl (
        .clk     (clk),
        .rst     (rst),
        .tick_ms (tick_ms),
        .link_ok (link_ok),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pair_x  (pair_x)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_ms = 1'b1;
        @(negedge clk);
        tick_ms = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic int slot_len(input int code);
        return 80 + (25 * code + 7) / 15;
    endfunction

    // Ticks until pair_x changes, capped.
    task automatic ticks_to_toggle(output int n);
        logic p0;
        p0 = pair_x;
        n  = 0;
        while (pair_x == p0 && n < 200) begin
            pulse_tick();
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        logic p;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(rd_data == 16'h0000, "R1 rd_data", rd_data, 0);
        check(pair_x == 1'b0, "R1 pair_x", pair_x, 0);

        // R2 field layout, reserved and read-only bits ignore writes
        wr(16'hFFAC);
        @(negedge clk);
        check(rd_data == 16'h00A0, "R2 readback", rd_data, 16'h00A0);

        // R3 manual mode, R9 status mirrors pair
        wr(16'h0002);
        @(negedge clk);
        check(pair_x == 1'b1, "R3 manual select 1", pair_x, 1);
        check(rd_data == 16'h0006, "R3 R9 register view", rd_data, 16'h0006);
        wr(16'h0000);
        @(negedge clk);
        check(pair_x == 1'b0, "R3 manual select 0", pair_x, 0);
        check(rd_data[3] == 1'b0, "R3 done low", rd_data[3], 0);

        // R5 sweep every slot code, two slots each
        for (int c = 0; c < 16; c++) begin
            wr(16'((c << 4) | 1));
            ticks_to_toggle(n);
            check(n == slot_len(c), "R5 first slot", n, slot_len(c));
            ticks_to_toggle(n);
            check(n == slot_len(c), "R5 second slot", n, slot_len(c));
            check(rd_data[2] == pair_x, "R9 status bit", rd_data[2], pair_x);
            check(rd_data[3] == 1'b0, "R5 no done while hunting", rd_data[3], 0);
        end

        // R4 manual bit ignored in auto mode
        p = pair_x;
        wr(p ? 16'h0001 : 16'h0003);
        repeat (3) @(negedge clk);
        check(pair_x == p, "R4 manual ignored", pair_x, p);

        // R6 lock when link present at expiry (code 0)
        link_ok = 1'b1;
        wr(16'h0001);
        p = pair_x;
        for (int i = 0; i < 79; i++) pulse_tick();
        check(rd_data[3] == 1'b0, "R6 not done before expiry", rd_data[3], 0);
        pulse_tick();
        check(rd_data[3] == 1'b1, "R6 done at expiry", rd_data[3], 1);
        check(pair_x == p, "R6 pair held at lock", pair_x, p);
        for (int i = 0; i < 200; i++) pulse_tick();
        check(pair_x == p && rd_data[3] == 1'b1, "R6 stays locked", pair_x, p);

        // R8 write while locked restarts
        wr(16'h0001);
        check(rd_data[3] == 1'b0, "R8 done cleared by write", rd_data[3], 0);
        check(pair_x == p, "R8 pair kept", pair_x, p);
        n = 0;
        while (rd_data[3] == 1'b0 && n < 200) begin
            pulse_tick();
            n++;
        end
        check(n == 80, "R8 fresh slot to relock", n, 80);

        // R7 link loss
        @(negedge clk);
        link_ok = 1'b0;
        @(negedge clk);
        check(rd_data[3] == 1'b0, "R7 done clears", rd_data[3], 0);
        check(pair_x == p, "R7 pair kept", pair_x, p);
        ticks_to_toggle(n);
        check(n == 80, "R7 fresh slot after loss", n, 80);

        // R3 back to manual clears done path
        wr(16'h0000);
        @(negedge clk);
        check(pair_x == 1'b0 && rd_data[3] == 1'b0, "R3 manual after auto", pair_x, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule